// File: doc/BRIEF.md
# Serial Two-Wire Register Access Target

This block sits on a two-wire serial bus (I2C) as a target device and gives an external bus controller read and write access to a small bank of on-chip control registers. It oversamples the serial clock and data lines with a fast system clock, recognises start and stop conditions, compares the first byte of each transaction with its own fixed 7-bit device address and acknowledges every byte it accepts by pulling the data line low.

In a write transaction the first byte after the address sets an internal register pointer, and every later byte is stored at the pointer, which then moves on by one. In a read transaction the block shifts out the register at the pointer, moves the pointer on, and keeps going for as long as the controller acknowledges. A repeated start after a pointer write is the usual way to read from a chosen register. The pointer wraps to zero past the last register, so one transaction may cover any number of consecutive registers. The data line is driven only as an open-drain pull-down enable; the register contents are presented in parallel to the rest of the chip.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the pull-down enable `sda_oe` is 0 and every register reads 0x00 on `regs_flat` (register i on bits [8*i+7 : 8*i]).
- R2: A falling SDA while SCL is high (start) begins reception of an address byte from any state, and a rising SDA while SCL is high (stop) returns the block to idle with `sda_oe` at 0, even in the middle of a byte.
- R3: Bytes are shifted most significant bit first; in the first byte after a start bits 7..1 are the device address and bit 0 is the direction (1 = read, 0 = write). Only an address equal to `DEV_ADDR` is acknowledged; otherwise the block leaves SDA released until the next start or stop.
- R4: An accepted byte is acknowledged by holding SDA low for the whole ninth SCL clock; SDA is released after that clock's falling edge.
- R5: In a write, the first byte after the address loads the pointer; each later byte is stored in the register at the pointer and the pointer then advances by one, with no limit on the count.
- R6: In a read, the block sends the register at the pointer most significant bit first, advances the pointer, and sends the next register for every byte the controller acknowledges (SDA low in the ninth clock).
- R7: A not-acknowledge (SDA high in the ninth clock) after a read byte ends the read: SDA stays released on every following SCL clock until the next start or stop.
- R8: When the pointer advances from register `NUM_REGS`-1 it wraps to 0, for both reads and writes.
- R9: A pointer value of `NUM_REGS` or more addresses no register: a read there returns 0x00, a write there changes no register, and the next advance from such a value yields 0.
- R10: `sda_oe` changes only on the clock after a falling SCL edge, a start or a stop, so SDA is never moved by the block while SCL is high.
- R11: A byte cut short by a start or a stop is discarded and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 leaves it to the pull-up |
| regs_flat | output | 8*NUM_REGS | All register contents, register i in bits [8*i+7 : 8*i] |

## Verification
The assertions rely on the bus being slow against the system clock, so that each SCL level and each controller-driven SDA level lasts several clock cycles after synchronization and a start, a stop and an SCL edge never land in the same sampled cycle. They also take for granted that the controller moves SDA only while SCL is low, except when it deliberately forms a start or a stop. The bench keeps to this by spacing every bus action a quarter SCL period of ten system cycles apart and by changing its SDA drive only between SCL phases, with start and stop built as separate steps with SCL held high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD
  } tgt_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;

  // True when the received first byte names this device.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx, input logic [6:0] dev);
    return rx[BYTE_W-1:1] == dev;
  endfunction

  // True when a pointer value selects an implemented register.
  function automatic logic ptr_valid(input logic [BYTE_W-1:0] p, input int unsigned nregs);
    return {24'd0, p} < nregs;
  endfunction

  // Next pointer value: wraps to zero past the last register.
  function automatic logic [BYTE_W-1:0] ptr_advance(input logic [BYTE_W-1:0] p,
                                                   input int unsigned nregs);
    if ({24'd0, p} + 32'd1 >= nregs) return '0;
    return p + 1'b1;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // Stage SYNC_STAGES-1 is the synchronized level, stage SYNC_STAGES the one before it.
  logic [SYNC_STAGES:0] scl_pipe;
  logic [SYNC_STAGES:0] sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_in};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now = scl_pipe[SYNC_STAGES-1];
  assign scl_old = scl_pipe[SYNC_STAGES];
  assign sda_s   = sda_pipe[SYNC_STAGES-1];
  assign sda_old = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [BYTE_W-1:0] regs [NUM_REGS];
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign hit = ptr_valid(addr, NUM_REGS);
  assign idx = addr[IDX_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       regs[i] <= '0;
      else if (wr_en && hit && (int'(idx) == i))        regs[i] <= wr_data;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = regs[i];
  end

  assign rd_data = hit ? regs[idx] : '0;

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int          NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              bus_idle,
  output logic              ignoring
);

  tgt_state_e        state;
  byte_kind_e        kind;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              go_tx;
  logic              ctl_ack;
  logic              byte_in;

  assign byte_in  = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  assign wr_en    = byte_in && (kind == BK_DATA);
  assign wr_data  = rx_sr;
  assign bus_idle = (state == ST_IDLE);
  assign ignoring = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= BK_ADDR;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      go_tx   <= 1'b0;
      ctl_ack <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state   <= ST_RX;
      kind    <= BK_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise) begin
            rx_sr   <= {rx_sr[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_in) begin
            bit_cnt <= '0;
            unique case (kind)
              BK_ADDR: begin
                if (addr_hit(rx_sr, DEV_ADDR)) begin
                  go_tx  <= rx_sr[0];
                  sda_oe <= 1'b1;
                  state  <= ST_RX_ACK;
                end else begin
                  state  <= ST_HOLD;
                end
              end
              BK_PTR: begin
                ptr    <= rx_sr;
                go_tx  <= 1'b0;
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
              end
              default: begin
                ptr    <= ptr_advance(ptr, NUM_REGS);
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (go_tx) begin
              tx_sr  <= rd_data;
              ptr    <= ptr_advance(ptr, NUM_REGS);
              sda_oe <= ~rd_data[BYTE_W-1];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              kind   <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_TX_ACK;
            end else begin
              tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~tx_sr[BYTE_W-2];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            ctl_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (ctl_ack) begin
              bit_cnt <= '0;
              tx_sr   <= rd_data;
              ptr     <= ptr_advance(ptr, NUM_REGS);
              sda_oe  <= ~rd_data[BYTE_W-1];
              state   <= ST_TX;
            end else begin
              state   <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic                       sda_in,
  output logic                       sda_oe,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [BYTE_W-1:0] ptr;
  logic [BYTE_W-1:0] rd_data;
  logic [BYTE_W-1:0] wr_data;
  logic              wr_en;
  logic              bus_idle;
  logic              ignoring;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe),
    .bus_idle  (bus_idle),
    .ignoring  (ignoring)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (ptr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .regs_flat (regs_flat)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic wr_en,
  input logic bus_idle,
  input logic ignoring
);

  // R10
  oe_moves_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R2
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2
  start_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  // R3 R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  // R11
  write_on_full_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (scl_fall && !bus_idle));

endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .bus_idle  (bus_idle),
  .ignoring  (ignoring)
);

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;

  localparam int         NREG = 8;
  localparam logic [6:0] DEV  = 7'h2A;
  localparam int         Q    = 10;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_flat;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_m),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .regs_flat (regs_flat)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  bit hi_stable = 1;

  logic [7:0] mdl [NREG];
  logic [7:0] mptr;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  event       rx_evt;
  logic [7:0] rx_byte;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Bench model of the pointer and register file.
  function automatic logic [7:0] mnext(input logic [7:0] p);
    if (p >= 8'(NREG - 1)) return 8'h00;
    return p + 8'd1;
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] p);
    if (p < 8'(NREG)) return mdl[p];
    return 8'h00;
  endfunction

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic s1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); s1 = sda_line; b[i] = s1; q();
      if (sda_line != s1) hi_stable = 0;
      scl_m = 1'b0;
    end
    q(); sda_m = give_ack ? 1'b0 : 1'b1;
    q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
    rx_byte = b;
    -> rx_evt;
  endtask

  task automatic check_regs(input string req, input string what);
    bit ok = 1;
    logic [7:0] bad_a = 0, bad_e = 0;
    for (int i = 0; i < NREG; i++) begin
      if (regs_flat[i*8 +: 8] !== mdl[i]) begin
        ok = 0; bad_a = regs_flat[i*8 +: 8]; bad_e = mdl[i];
      end
    end
    check(ok, req, what, bad_a, bad_e);
  endtask

  task automatic wr_txn(input logic [7:0] p, input int n, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3,
                        input string req);
    logic a;
    bit all_ack = 1;
    logic [7:0] d [4];
    d = '{d0, d1, d2, d3};
    do_start();
    send_byte({DEV, 1'b0}, a); all_ack &= a;
    send_byte(p, a);           all_ack &= a;
    mptr = p;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); all_ack &= a;
      if (mptr < 8'(NREG)) mdl[mptr] = d[i];
      mptr = mnext(mptr);
    end
    do_stop();
    check(all_ack, req, "write bytes acknowledged (R4)", {31'd0, all_ack}, 1);
  endtask

  task automatic rd_txn(input logic [7:0] p, input int n, input string req);
    logic a;
    bit all_ack = 1;
    logic [7:0] b;
    do_start();
    send_byte({DEV, 1'b0}, a); all_ack &= a;
    send_byte(p, a);           all_ack &= a;
    mptr = p;
    do_start();
    send_byte({DEV, 1'b1}, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mread(mptr));
      tag_q.push_back(req);
      mptr = mnext(mptr);
      recv_byte(i < n - 1, b);
    end
    do_stop();
    check(all_ack, req, "read setup acknowledged", {31'd0, all_ack}, 1);
  endtask

  // Scoreboard monitor: compares every byte the bench receives with the queue.
  initial begin
    forever begin
      logic [7:0] e;
      string t;
      @(rx_evt);
      if (exp_q.size() == 0) begin
        check(0, "R6", "unexpected read byte", rx_byte, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rx_byte === e, t, "read byte", rx_byte, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    mptr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    q();

    // R1 reset state
    check(sda_oe == 1'b0, "R1", "sda_oe after reset", {31'd0, sda_oe}, 0);
    check_regs("R1", "registers after reset");

    // R3 wrong address is not acknowledged and writes nothing
    do_start();
    send_byte({7'h15, 1'b0}, a);
    check(a == 1'b0, "R3", "foreign address ack", {31'd0, a}, 0);
    send_byte(8'h01, a);
    send_byte(8'hEE, a);
    check(a == 1'b0, "R3", "byte after foreign address ack", {31'd0, a}, 0);
    do_stop();
    check_regs("R3", "registers after foreign write");

    // R4 acknowledge held through the ninth clock, then released
    do_start();
    send_bits({DEV, 1'b0}, 8);
    sda_m = 1'b1; q();
    check(sda_line == 1'b0, "R4", "ack low before ninth rise", {31'd0, sda_line}, 0);
    scl_m = 1'b1; q(); q();
    check(sda_line == 1'b0, "R4", "ack low late in ninth high", {31'd0, sda_line}, 0);
    scl_m = 1'b0; q();
    check(sda_oe == 1'b0, "R4", "ack released after ninth fall", {31'd0, sda_oe}, 0);
    do_stop();

    // R5 single and multi-byte writes
    wr_txn(8'h03, 1, 8'h5A, 8'h00, 8'h00, 8'h00, "R5");
    check_regs("R5", "single write");
    wr_txn(8'h01, 4, 8'h11, 8'h22, 8'h33, 8'h44, "R5");
    check_regs("R5", "multi write");

    // R8 write wrap past the last register
    wr_txn(8'(NREG - 2), 3, 8'h66, 8'h77, 8'h88, 8'h00, "R8");
    check_regs("R8", "write wrap");

    // R6 sequential read, R8 read wrap
    rd_txn(8'h01, 4, "R6");
    rd_txn(8'(NREG - 2), 4, "R8");

    // R9 unimplemented pointer: write ignored, then wrap to 0
    wr_txn(8'h40, 2, 8'hAA, 8'hBB, 8'h00, 8'h00, "R9");
    check_regs("R9", "write to unimplemented pointer");
    rd_txn(8'h40, 2, "R9");

    // R7 not-acknowledge ends the read, SDA stays released
    do_start();
    send_byte({DEV, 1'b1}, a);
    check(a == 1'b1, "R7", "read address ack", {31'd0, a}, 1);
    exp_q.push_back(mread(mptr)); tag_q.push_back("R7");
    mptr = mnext(mptr);
    recv_byte(1'b0, b);
    begin
      bit low_seen = 0;
      for (int i = 0; i < 9; i++) begin
        q(); scl_m = 1'b1; q();
        if (sda_line == 1'b0) low_seen = 1;
        q(); scl_m = 1'b0; q();
      end
      check(low_seen == 0, "R7", "SDA driven after nack", {31'd0, low_seen}, 0);
    end
    do_stop();

    // R2 R11 stop in the middle of a data byte
    do_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h02, a);
    send_bits(8'hFF, 4);
    do_stop();
    q();
    check(sda_oe == 1'b0, "R2", "sda_oe after mid-byte stop", {31'd0, sda_oe}, 0);
    check_regs("R11", "registers after mid-byte stop");

    // R2 R11 repeated start in the middle of a data byte
    do_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h05, a);
    send_bits(8'hC3, 3);
    do_start();
    send_byte({DEV, 1'b0}, a);
    check(a == 1'b1, "R2", "address ack after mid-byte start", {31'd0, a}, 1);
    send_byte(8'h04, a);
    send_byte(8'h9C, a);
    do_stop();
    mdl[4] = 8'h9C;
    check_regs("R11", "partial byte discarded, next write lands");

    // R10 SDA held steady while SCL high during reads
    check(hi_stable == 1, "R10", "SDA moved while SCL high", {31'd0, hi_stable}, 1);

    q();
    check(exp_q.size() == 0, "R6", "scoreboard left over", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule